// File: doc/BRIEF.md
# Five-Channel Sample Frame Serializer

This block sits between five parallel sample queues and a byte-wide serial transmitter. It removes one sample set at a time from the queues, keeping the low 16 bits of every queue word. Each set becomes a twelve-byte frame: the five channel values, each sent upper byte first, followed by a two-byte sync trailer. The bytes go out over a valid/ready handshake, one byte per accepted transfer. A start command sends a packet with a programmable number of sample sets and ends it with a one-clock done pulse.

A flush command cleans out stale data. It holds the converter reset line low and pops every queue once per clock until the shared empty flag rises, then releases the line. All five queue words of a set are captured into a holding register in the cycle they are popped, so the queues refill while the frame is being sent.

Top module: `sample_frame_serializer`

## Requirements
- R1: A sample set is popped only while `qEmpty` is low. All five `qRead` bits pulse together for one cycle per set. While `qEmpty` stays high the block waits, sending no byte and popping nothing.
- R2: Only bits [15:0] of each channel word are sent; bits above 15 never reach `txData`.
- R3: Frame bytes 0 to 9 carry channel 1 through channel 5 in that order. Each channel's bits [15:8] come first, then bits [7:0]. Channel c occupies `qData[32*(c-1) +: 32]` at the default width.
- R4: Frame bytes 10 and 11 are always 0xF0 and then 0x5A.
- R5: A byte counts as sent only in a cycle where `txValid` and `txReady` are both high. While `txValid` is high and `txReady` is low, `txValid` stays high and `txData` holds its value.
- R6: A packet holds `pktLen` sample sets. A `pktLen` of 0 selects the default of 4096 sets. `pktLen` is sampled in the cycle the start is taken.
- R7: `pktDone` is high for exactly one clock, in the cycle after the last trailer byte of the last set is accepted. The block is then idle and pops nothing until the next start.
- R8: During a flush, `adcRstN` is low and one word is popped from each queue every cycle while `qEmpty` is low. When `qEmpty` is high, `adcRstN` returns high and no byte is sent.
- R9: `startReq` and `flushReq` have no effect while a packet or a flush is in progress. If both are high while idle, the start wins.
- R10: A synchronous active-low reset returns the block to idle: `txValid`, `qRead` and `pktDone` are low and `adcRstN` is high, including when reset arrives mid-packet or mid-flush.
- R11: A frame carries the queue contents as they were in the pop cycle. Later changes on `qData` do not alter the frame in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous reset, active low |
| startReq | input | 1 | Start a packet (taken when idle) |
| flushReq | input | 1 | Start a flush (taken when idle) |
| pktLen | input | 13 | Sample sets per packet, 0 selects 4096 |
| qEmpty | input | 1 | Shared empty flag of the queues |
| qData | input | 160 | Head words of the five queues, channel 1 in the low word |
| qRead | output | 5 | Pop strobes, one per queue |
| adcRstN | output | 1 | Converter reset, active low |
| txData | output | 8 | Byte toward the transmitter |
| txValid | output | 1 | `txData` holds a byte to send |
| txReady | input | 1 | Transmitter can take a byte |
| pktDone | output | 1 | One-clock packet completion pulse |

## Verification
The assertions assume the queues present a valid head word on all five channels whenever the shared `qEmpty` flag is low. They also assume that a pop advances all five queues together. The bench queue model meets this by keeping one read pointer for all channels. In its streaming mode it holds `qEmpty` low and derives each word from the pop count, so the data changes right after every capture. `txReady` is driven either steadily high or from a pseudo-random sequence. All stimulus changes shortly after the rising edge, so no handshake input moves at the sampling edge.

// File: rtl/sfs_pkg.sv
package sfs_pkg;
  localparam int NUM_CH      = 5;
  localparam int SAMPLE_W    = 16;
  localparam int FRAME_BYTES = 2 * NUM_CH + 2;
  localparam int IDX_W       = $clog2(FRAME_BYTES);
  localparam logic [7:0] SYNC_FIRST  = 8'hF0;
  localparam logic [7:0] SYNC_SECOND = 8'h5A;

  typedef enum logic [1:0] {ST_IDLE, ST_WAIT, ST_SEND, ST_FLUSH} sfsState_t;

  typedef struct packed {
    logic             capture;
    logic [IDX_W-1:0] byteSel;
  } dpCtl_t;
endpackage

// File: rtl/sfs_ctrl.sv
module sfs_ctrl
  import sfs_pkg::*;
#(
  parameter int LEN_W       = 13,
  parameter int DEFAULT_LEN = 4096
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startReq,
  input  logic             flushReq,
  input  logic [LEN_W-1:0] pktLen,
  input  logic             qEmpty,
  input  logic             txReady,
  output logic             qPop,
  output logic             adcRstN,
  output logic             txValid,
  output logic             pktDone,
  output dpCtl_t           dpCtl
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_BYTES - 1);

  sfsState_t        state;
  logic [IDX_W-1:0] byteIdx;
  logic [LEN_W-1:0] setsLeft;

  always_comb begin
    qPop            = ((state == ST_WAIT) || (state == ST_FLUSH)) && !qEmpty;
    adcRstN         = (state != ST_FLUSH);
    txValid         = (state == ST_SEND);
    dpCtl.capture   = (state == ST_WAIT) && !qEmpty;
    dpCtl.byteSel   = byteIdx;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      byteIdx  <= '0;
      setsLeft <= '0;
      pktDone  <= 1'b0;
    end else begin
      pktDone <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (startReq) begin
            setsLeft <= (pktLen == '0) ? LEN_W'(DEFAULT_LEN) : pktLen;
            state    <= ST_WAIT;
          end else if (flushReq) begin
            state <= ST_FLUSH;
          end
        end
        ST_WAIT: begin
          if (!qEmpty) begin
            byteIdx <= '0;
            state   <= ST_SEND;
          end
        end
        ST_SEND: begin
          if (txReady) begin
            if (byteIdx == LAST_IDX) begin
              byteIdx <= '0;
              if (setsLeft == LEN_W'(1)) begin
                state   <= ST_IDLE;
                pktDone <= 1'b1;
              end else begin
                setsLeft <= setsLeft - LEN_W'(1);
                state    <= ST_WAIT;
              end
            end else begin
              byteIdx <= byteIdx + IDX_W'(1);
            end
          end
        end
        ST_FLUSH: begin
          if (qEmpty) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R7: completion strobe lasts a single clock
  p_done_single_r7: assert property (@(posedge clk) disable iff (!rstN)
    pktDone |=> !pktDone);

  // R7: completion leaves the controller idle
  p_done_idle_r7: assert property (@(posedge clk) disable iff (!rstN)
    pktDone |-> (state == ST_IDLE));

  // R9: activity only begins from a request seen while idle
  p_leave_idle_r9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(state != ST_IDLE) |-> $past(startReq || flushReq));

  // R8: no byte and no completion while the converter is held in reset
  p_flush_quiet_r8: assert property (@(posedge clk) disable iff (!rstN)
    !adcRstN |-> (!txValid && !pktDone));

  // R5: an offered byte is not withdrawn before it is taken
  p_valid_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    (txValid && !txReady) |=> txValid);
endmodule

// File: rtl/sfs_datapath.sv
module sfs_datapath
  import sfs_pkg::*;
#(
  parameter int WORD_W = 32
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  dpCtl_t                   dpCtl,
  input  logic [NUM_CH*WORD_W-1:0] qData,
  output logic [7:0]               txData
);
  localparam int CH_W = $clog2(NUM_CH + 1);

  logic [SAMPLE_W-1:0] holdReg [NUM_CH];

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_hold
    always_ff @(posedge clk) begin
      if (!rstN)              holdReg[ch] <= '0;
      else if (dpCtl.capture) holdReg[ch] <= qData[ch*WORD_W +: SAMPLE_W];
    end
  end

  logic [CH_W-1:0] chSel;
  logic            lowHalf;

  always_comb begin
    chSel   = CH_W'(dpCtl.byteSel >> 1);
    lowHalf = dpCtl.byteSel[0];
    txData  = SYNC_SECOND;
    if (32'(dpCtl.byteSel) < 2 * NUM_CH) begin
      txData = lowHalf ? holdReg[chSel][7:0] : holdReg[chSel][15:8];
    end else if (32'(dpCtl.byteSel) == 2 * NUM_CH) begin
      txData = SYNC_FIRST;
    end
  end

  // R2: capture never reads past the queue word width
  initial assert (WORD_W >= SAMPLE_W);
endmodule

// File: rtl/sample_frame_serializer.sv
module sample_frame_serializer
  import sfs_pkg::*;
#(
  parameter int WORD_W      = 32,
  parameter int LEN_W       = 13,
  parameter int DEFAULT_LEN = 4096
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     startReq,
  input  logic                     flushReq,
  input  logic [LEN_W-1:0]         pktLen,
  input  logic                     qEmpty,
  input  logic [NUM_CH*WORD_W-1:0] qData,
  output logic [NUM_CH-1:0]        qRead,
  output logic                     adcRstN,
  output logic [7:0]               txData,
  output logic                     txValid,
  input  logic                     txReady,
  output logic                     pktDone
);
  dpCtl_t dpCtl;
  logic   qPop;

  sfs_ctrl #(.LEN_W(LEN_W), .DEFAULT_LEN(DEFAULT_LEN)) u_ctrl (
    .clk(clk), .rstN(rstN), .startReq(startReq), .flushReq(flushReq),
    .pktLen(pktLen), .qEmpty(qEmpty), .txReady(txReady), .qPop(qPop),
    .adcRstN(adcRstN), .txValid(txValid), .pktDone(pktDone), .dpCtl(dpCtl)
  );

  sfs_datapath #(.WORD_W(WORD_W)) u_dp (
    .clk(clk), .rstN(rstN), .dpCtl(dpCtl), .qData(qData), .txData(txData)
  );

  assign qRead = {NUM_CH{qPop}};

  // R5: the offered byte value holds until the transmitter takes it
  p_byte_stable_r5: assert property (@(posedge clk) disable iff (!rstN)
    (txValid && !txReady) |=> (txValid && $stable(txData)));

  // R1: nothing is popped while the queues report empty
  p_no_pop_empty_r1: assert property (@(posedge clk) disable iff (!rstN)
    qEmpty |-> (qRead == '0));
endmodule

// File: tb/sample_frame_serializer_test.sv
`timescale 1ns/1ps
module sample_frame_serializer_test;
  localparam int NCH = 5;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         startReq = 1'b0, flushReq = 1'b0;
  logic [12:0]  pktLen = '0;
  logic         qEmpty;
  logic [159:0] qData;
  logic [4:0]   qRead;
  logic         adcRstN, txValid, pktDone;
  logic [7:0]   txData;
  logic         txReady = 1'b1;

  always #2.5 clk = ~clk;

  sample_frame_serializer uut (
    .clk(clk), .rstN(rstN), .startReq(startReq), .flushReq(flushReq),
    .pktLen(pktLen), .qEmpty(qEmpty), .qData(qData), .qRead(qRead),
    .adcRstN(adcRstN), .txData(txData), .txValid(txValid),
    .txReady(txReady), .pktDone(pktDone)
  );

  int checks = 0, errors = 0;

  task automatic chk(input bit ok, input string req, input logic [95:0] act, input logic [95:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // ---------------- stimulus table: five queue words -> ten payload bytes
  localparam logic [159:0] VEC_IN [6] = '{
    {32'h0000_0005, 32'h0000_0004, 32'h0000_0003, 32'h0000_0002, 32'h0000_0001},
    {32'hFFFF_EEEE, 32'hDEAD_DDDD, 32'h1234_CCCC, 32'h8000_BBBB, 32'hABCD_AAAA},
    {32'h0001_8001, 32'hF00F_7FFE, 32'h5555_00FF, 32'hAAAA_FF00, 32'h9999_1357},
    {32'h7777_5AF0, 32'h6666_F05A, 32'hFFFF_0000, 32'h0000_FFFF, 32'h3C3C_2468},
    {32'hCAFE_0102, 32'hBABE_0304, 32'hFACE_0506, 32'hBEEF_0708, 32'hD00D_090A},
    {32'h1111_FEDC, 32'h2222_BA98, 32'h3333_7654, 32'h4444_3210, 32'h5555_0F1E}};
  localparam logic [79:0] VEC_EXP [6] = '{
    80'h0001_0002_0003_0004_0005,
    80'hAAAA_BBBB_CCCC_DDDD_EEEE,
    80'h1357_FF00_00FF_7FFE_8001,
    80'h2468_FFFF_0000_F05A_5AF0,
    80'h090A_0708_0506_0304_0102,
    80'h0F1E_3210_7654_BA98_FEDC};

  // ---------------- queue model
  logic [31:0] qMem [NCH][64];
  logic [5:0]  wrPtr = '0, rdPtr = '0;
  int          popCount = 0;
  bit          autoFeed = 1'b0;

  function automatic logic [31:0] feedWord(input int k, input int c);
    return {16'hFACE, 4'(c + 1), 12'(k)};
  endfunction

  always_comb begin
    qEmpty = autoFeed ? 1'b0 : (wrPtr == rdPtr);
    for (int c = 0; c < NCH; c++)
      qData[c*32 +: 32] = autoFeed ? feedWord(popCount, c) : qMem[c][rdPtr];
  end

  always @(posedge clk) begin
    if (rstN && (|qRead)) begin
      popCount <= popCount + 1;
      if (!autoFeed) rdPtr <= rdPtr + 6'd1;
    end
  end

  task automatic pushSet(input logic [159:0] w);
    for (int c = 0; c < NCH; c++) qMem[c][wrPtr] = w[c*32 +: 32];
    wrPtr = wrPtr + 6'd1;
  endtask

  // ---------------- transmitter model and byte collector
  bit          readyRandom = 1'b0;
  logic [15:0] lfsr = 16'hACE1;
  logic [7:0]  rxBuf [256];
  int          rxTotal = 0;
  bit          heldPending = 1'b0;
  logic [7:0]  heldByte;

  initial forever begin
    @(posedge clk); #1;
    if (readyRandom) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      txReady = lfsr[0];
    end else txReady = 1'b1;
  end

  always @(negedge clk) begin
    if (rstN) begin
      if (heldPending)
        chk(txValid && txData == heldByte, "R5 held byte", {87'd0, txValid, txData}, {88'd1, heldByte});
      heldPending <= txValid && !txReady;
      heldByte    <= txData;
      if (txValid && txReady) begin
        rxBuf[rxTotal % 256] <= txData;
        rxTotal <= rxTotal + 1;
      end
    end else heldPending <= 1'b0;
  end

  // ---------------- helpers
  task automatic startPkt(input int n);
    @(posedge clk); #1; pktLen = 13'(n); startReq = 1'b1;
    @(posedge clk); #1; startReq = 1'b0;
  endtask

  task automatic waitDone(input int maxCyc, input int expBytes, input int base);
    int n = 0;
    do begin @(negedge clk); #1; n++; end while (!pktDone && n < maxCyc);
    chk(pktDone == 1'b1, "R7 done pulse seen", 96'(pktDone), 96'd1);
    chk(rxTotal - base == expBytes, "R6 byte count", 96'(rxTotal - base), 96'(expBytes));
    @(negedge clk); #1;
    chk(pktDone == 1'b0, "R7 done lasts one clock", 96'(pktDone), 96'd0);
  endtask

  function automatic logic [95:0] frameAt(input int start);
    logic [95:0] f;
    for (int b = 0; b < 12; b++) f[95 - 8*b -: 8] = rxBuf[(start + b) % 256];
    return f;
  endfunction

  function automatic logic [95:0] feedFrame(input int k);
    logic [95:0] f;
    for (int c = 0; c < NCH; c++) f[95 - 16*c -: 16] = feedWord(k, c)[15:0];
    f[15:0] = 16'hF05A;
    return f;
  endfunction

  // ---------------- watchdog
  initial begin
    #(5ns * 190000);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  // ---------------- main sequence
  initial begin
    int base, pop0;
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    @(negedge clk); #1;
    // R10 reset state
    chk(!txValid && qRead == 0 && adcRstN && !pktDone, "R10 reset state",
        {92'd0, txValid, |qRead, adcRstN, pktDone}, {92'd0, 4'b0010});

    // table walk, ready always high then random (R1 R2 R3 R4 R5 R6)
    for (int pass = 0; pass < 2; pass++) begin
      readyRandom = (pass == 1);
      for (int i = 0; i < 6; i++) pushSet(VEC_IN[i]);
      base = rxTotal; pop0 = popCount;
      startPkt(6);
      waitDone(2000, 72, base);
      chk(popCount - pop0 == 6, "R1 one pop per set", 96'(popCount - pop0), 96'd6);
      for (int i = 0; i < 6; i++)
        chk(frameAt(base + 12*i) == {VEC_EXP[i], 16'hF05A}, "R2 R3 R4 frame content",
            frameAt(base + 12*i), {VEC_EXP[i], 16'hF05A});
    end
    readyRandom = 1'b0;

    // R1 wait while empty, R9 requests ignored while busy
    base = rxTotal; pop0 = popCount;
    startPkt(2);
    repeat (20) @(negedge clk);
    #1 chk(!txValid && popCount == pop0, "R1 waits while empty",
           {95'd0, txValid}, 96'd0);
    @(posedge clk); #1 flushReq = 1'b1; startReq = 1'b1;
    @(posedge clk); #1 flushReq = 1'b0; startReq = 1'b0;
    @(negedge clk); #1
    chk(adcRstN == 1'b1, "R9 flush ignored in packet", 96'(adcRstN), 96'd1);
    pushSet(VEC_IN[1]); pushSet(VEC_IN[2]);
    waitDone(500, 24, base);
    chk(frameAt(base + 12) == {VEC_EXP[2], 16'hF05A}, "R3 frame after wait",
        frameAt(base + 12), {VEC_EXP[2], 16'hF05A});
    pushSet(VEC_IN[3]); pop0 = popCount;
    repeat (20) @(negedge clk);
    #1 chk(popCount == pop0 && !txValid, "R9 start ignored in packet",
           96'(popCount - pop0), 96'd0);

    // R8 flush (one set already queued + four more)
    for (int i = 0; i < 4; i++) pushSet(VEC_IN[i]);
    base = rxTotal; pop0 = popCount;
    @(posedge clk); #1 flushReq = 1'b1;
    @(posedge clk); #1 flushReq = 1'b0;
    @(negedge clk); #1
    chk(adcRstN == 1'b0, "R8 reset line low in flush", 96'(adcRstN), 96'd0);
    @(posedge clk); #1 startReq = 1'b1;
    @(posedge clk); #1 startReq = 1'b0;
    for (int n = 0; n < 50 && !adcRstN; n++) begin @(negedge clk); #1; end
    chk(adcRstN && popCount - pop0 == 5, "R8 flush drains queues",
        96'(popCount - pop0), 96'd5);
    chk(rxTotal == base && wrPtr == rdPtr, "R8 no byte in flush",
        96'(rxTotal - base), 96'd0);
    pushSet(VEC_IN[0]); pop0 = popCount;
    repeat (20) @(negedge clk);
    #1 chk(popCount == pop0 && !txValid, "R9 start ignored in flush",
           96'(popCount - pop0), 96'd0);
    // drain the leftover set with a one-set packet (R6 length one)
    base = rxTotal;
    startPkt(1);
    waitDone(200, 12, base);
    chk(frameAt(base) == {VEC_EXP[0], 16'hF05A}, "R6 single set packet",
        frameAt(base), {VEC_EXP[0], 16'hF05A});

    // R11 streaming queues change right after each pop
    autoFeed = 1'b1; readyRandom = 1'b1;
    base = rxTotal; pop0 = popCount;
    startPkt(3);
    waitDone(1000, 36, base);
    for (int j = 0; j < 3; j++)
      chk(frameAt(base + 12*j) == feedFrame(pop0 + j), "R11 captured set",
          frameAt(base + 12*j), feedFrame(pop0 + j));
    pop0 = popCount;
    repeat (5) @(negedge clk);
    #1 chk(popCount == pop0, "R7 idle after done", 96'(popCount - pop0), 96'd0);

    // R6 default length
    readyRandom = 1'b0;
    base = rxTotal; pop0 = popCount;
    startPkt(0);
    waitDone(80000, 4096 * 12, base);
    chk(popCount - pop0 == 4096, "R6 default length", 96'(popCount - pop0), 96'd4096);
    chk(frameAt(rxTotal - 12) == feedFrame(popCount - 1), "R4 last frame",
        frameAt(rxTotal - 12), feedFrame(popCount - 1));

    // R10 reset mid-packet and mid-flush
    startPkt(5);
    repeat (30) @(posedge clk);
    #1 rstN = 1'b0;
    @(posedge clk); #1 rstN = 1'b1;
    @(negedge clk); #1
    chk(!txValid && qRead == 0 && adcRstN, "R10 reset mid-packet",
        {93'd0, txValid, |qRead, adcRstN}, {93'd0, 3'b001});
    @(posedge clk); #1 flushReq = 1'b1;
    @(posedge clk); #1 flushReq = 1'b0;
    repeat (10) @(posedge clk);
    @(negedge clk); #1
    chk(adcRstN == 1'b0, "R8 flush holds while non-empty", 96'(adcRstN), 96'd0);
    @(posedge clk); #1 rstN = 1'b0;
    @(posedge clk); #1 rstN = 1'b1;
    @(negedge clk); #1
    chk(adcRstN && qRead == 0 && !pktDone, "R10 reset mid-flush",
        {94'd0, adcRstN, |qRead}, {94'd0, 2'b10});

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule